// File: doc/BRIEF.md
# PCIe Transmit Credit Gate

This block sits between an application's transmit scheduler and a PCIe core. It decides whether a requested transaction layer packet may go out now, based on the flow-control credit limits that the core publishes and on a running total of credits already spent. Credits are tracked for six types: a header and a data count for each of the posted, non-posted and completion classes.

Credits are spent from two sources. The core spends some on its own traffic, such as read completions and error messages, and reports each one as a single-cycle pulse. The application spends the rest through packets granted by this block. Both sources are summed into one counter per type. The core shows one class's limits at a time, so the block steps a class selector round-robin and keeps a copy of each class's header and data limits. A type that the core marks as unlimited is never checked. Nothing is granted and no consumption is counted while the data link is down.

The requester holds `req_valid` with the packet's class, data flag and payload length. `grant` or `stall` answers in the same cycle. A granted request must be dropped or replaced at the next clock edge.

Top module: `pcie_tx_credit_gate`

## Requirements
- R1: During and directly after reset, `grant` and `stall` are 0, `lim_sel` is 2'b00 and every consumed count is zero.
- R2: While `link_up` is 0, `grant` stays 0 and pulses on `core_use` are not counted.
- R3: `lim_sel` steps 00, 01, 10, 00, … one step per clock and never shows 11. The value on `lim_hdr`/`lim_dat` is stored as the limit of the selected class (00 posted, 01 non-posted, 10 completion). A class is not granted until its limits have been stored since `link_up` last rose.
- R4: A request needs one header credit of its class (`req_class` 0 posted, 1 non-posted, 2 completion). When `req_data` is 1 it also needs ceil(`req_dw`/4) data credits of that class, one data credit being 16 bytes.
- R5: Header counts are 8 bits and data counts are 12 bits. A needed type passes when (limit − consumed) modulo 2^width is at least its cost, so a limit that has wrapped below the count still gives room.
- R6: `grant` is 1 only when `req_valid` is 1, `link_up` is 1, the class limits are stored and every needed type passes. `stall` is 1 exactly when `req_valid` is 1 and `grant` is 0.
- R7: At each clock edge with `grant` 1, the request's costs are added to the consumed counts of its class.
- R8: Each set bit of `core_use` adds one credit to its type. Bit 5 is posted header, 4 posted data, 3 non-posted header, 2 non-posted data, 1 completion header and 0 completion data.
- R9: When a grant and a core pulse hit the same type in one cycle, both amounts are added.
- R10: A type whose `unlimited` bit (same bit order as `core_use`) is 1 always passes.
- R11: While `link_up` is 0, all consumed counts return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Data link is up |
| core_use | input | 6 | Single-cycle credit pulses from the core's own traffic |
| unlimited | input | 6 | Per-type unlimited-credit flags |
| lim_sel | output | 2 | Class whose limits the core should show |
| lim_hdr | input | 8 | Header credit limit of the selected class |
| lim_dat | input | 12 | Data credit limit of the selected class |
| req_valid | input | 1 | Packet request present |
| req_class | input | 2 | Packet class: 0 posted, 1 non-posted, 2 completion |
| req_data | input | 1 | Packet carries a payload |
| req_dw | input | 10 | Payload length in dwords |
| grant | output | 1 | Packet may be sent this cycle |
| stall | output | 1 | Request is present but held back |

## Verification
A consumed count that is off by even one credit shows at the ports no later than the next request that brings its class to the limit. It appears as a `grant` where `stall` was due, or the reverse, so the table drives each class to exactly its limit and one past it. Lost same-cycle additions, pulses counted while the link is down, and counts that survive a link drop all show up as one extra grant in the request that follows. A wrong limit-capture slot shows up in the class that was mis-stored within three cycles of a limit change.

// File: rtl/tx_credit_pkg.sv
// Shared definitions for the transmit credit gate.
// Assumes the type order used on the core's pulse and unlimited vectors:
// index 5..0 = posted hdr, posted data, non-posted hdr, non-posted data,
// completion hdr, completion data.
package tx_credit_pkg;
    localparam int NUM_TYPES   = 6;
    localparam int NUM_CLASSES = 3;

    typedef enum logic [1:0] {
        CLS_POSTED = 2'd0,
        CLS_NONPOST = 2'd1,
        CLS_CPL = 2'd2
    } tlp_class_e;

    // Class that owns a type index.
    function automatic logic [1:0] class_of_type(input int t);
        return 2'((NUM_TYPES - 1 - t) / 2);
    endfunction

    // Odd indices are header types.
    function automatic logic is_hdr_type(input int t);
        return (t % 2) == 1;
    endfunction
endpackage

// File: rtl/credit_limit_sel.sv
// Steps the class selector round-robin and keeps a copy of every class's
// header and data limit. Assumes the core's limit outputs follow the
// selector within the same cycle. All stored flags clear while the link is down.
module credit_limit_sel
    import tx_credit_pkg::*;
#(
    parameter int HDR_W = 8,
    parameter int DAT_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            link_up,
    input  logic [HDR_W-1:0]                lim_hdr,
    input  logic [DAT_W-1:0]                lim_dat,
    output logic [1:0]                      sel,
    output logic [NUM_CLASSES-1:0][HDR_W-1:0] hdr_lim,
    output logic [NUM_CLASSES-1:0][DAT_W-1:0] dat_lim,
    output logic [NUM_CLASSES-1:0]          seen
);
    localparam logic [1:0] LAST_SEL = 2'(NUM_CLASSES - 1);

    // Round-robin class selector.
    always_ff @(posedge clk) begin
        if (!rst_n)                sel <= '0;
        else if (sel == LAST_SEL)  sel <= '0;
        else                       sel <= sel + 2'd1;
    end

    // Store the limits on show for the selected class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_lim <= '0;
            dat_lim <= '0;
            seen    <= '0;
        end else if (!link_up) begin
            seen    <= '0;
        end else begin
            hdr_lim[sel] <= lim_hdr;
            dat_lim[sel] <= lim_dat;
            seen[sel]    <= 1'b1;
        end
    end
endmodule

// File: rtl/credit_tally.sv
// One consumed-credit counter of width W with its room check.
// Adds the application amount and a single core credit in the same cycle.
// Assumes modulo-2^W arithmetic against the limit.
module credit_tally #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] add_app,
    input  logic         add_core,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] cost,
    input  logic         unl,
    output logic         room
);
    logic [W-1:0] used;
    logic [W-1:0] avail;

    // Running consumption, cleared while the link is down.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) used <= '0;
        else                 used <= used + add_app + W'(add_core);
    end

    // Room check with wrap-around difference.
    always_comb begin
        avail = limit - used;
        room  = unl || (avail >= cost);
    end
endmodule

// File: rtl/pcie_tx_credit_gate.sv
// Grants or stalls transmit requests from per-type consumed counts and the
// stored class limits. Assumes a granted request is removed or replaced
// at the next clock edge, and that core pulses obey the one-header (plus
// optional one-data) per cycle rule.
module pcie_tx_credit_gate
    import tx_credit_pkg::*;
#(
    parameter int HDR_W = 8,
    parameter int DAT_W = 12,
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic [5:0]       core_use,
    input  logic [5:0]       unlimited,
    output logic [1:0]       lim_sel,
    input  logic [HDR_W-1:0] lim_hdr,
    input  logic [DAT_W-1:0] lim_dat,
    input  logic             req_valid,
    input  logic [1:0]       req_class,
    input  logic             req_data,
    input  logic [LEN_W-1:0] req_dw,
    output logic             grant,
    output logic             stall
);
    localparam int COST_W = LEN_W - 1;

    logic [NUM_CLASSES-1:0][HDR_W-1:0] hdr_lim;
    logic [NUM_CLASSES-1:0][DAT_W-1:0] dat_lim;
    logic [NUM_CLASSES-1:0]            seen;
    logic [3:0]                        seen_ext;
    logic [COST_W-1:0]                 dat_cost;
    logic [NUM_TYPES-1:0]              room;
    logic [NUM_TYPES-1:0]              core_live;
    logic                              class_ok;

    credit_limit_sel #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_lim (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .lim_hdr(lim_hdr), .lim_dat(lim_dat),
        .sel(lim_sel), .hdr_lim(hdr_lim), .dat_lim(dat_lim), .seen(seen)
    );

    // Data credits: payload dwords divided by four, rounded up.
    always_comb begin
        dat_cost  = COST_W'((LEN_W'(1) + (req_dw + LEN_W'(2))) >> 2);
        if (req_dw > LEN_W'({LEN_W{1'b1}} - 3)) dat_cost = COST_W'(({1'b0, req_dw} + 3) >> 2);
        core_live = link_up ? core_use : '0;
        seen_ext  = {1'b0, seen};
        class_ok  = (req_class != 2'd3) && seen_ext[req_class];
    end

    // One counter per type, sized by header or data width.
    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
        localparam logic [1:0] CLS = class_of_type(t);
        localparam bit         HDR = is_hdr_type(t);
        logic need;
        always_comb need = req_valid && (req_class == CLS) && (HDR || req_data);
        if (HDR) begin : g_hdr
            logic [HDR_W-1:0] cost;
            always_comb cost = need ? HDR_W'(1) : '0;
            credit_tally #(.W(HDR_W)) u_tally (
                .clk(clk), .rst_n(rst_n), .clear(!link_up),
                .add_app(grant ? cost : '0), .add_core(core_live[t]),
                .limit(hdr_lim[CLS]), .cost(cost), .unl(unlimited[t]),
                .room(room[t])
            );
        end else begin : g_dat
            logic [DAT_W-1:0] cost;
            always_comb cost = need ? DAT_W'(dat_cost) : '0;
            credit_tally #(.W(DAT_W)) u_tally (
                .clk(clk), .rst_n(rst_n), .clear(!link_up),
                .add_app(grant ? cost : '0), .add_core(core_live[t]),
                .limit(dat_lim[CLS]), .cost(cost), .unl(unlimited[t]),
                .room(room[t])
            );
        end
    end

    // Final decision for the presented request.
    always_comb begin
        grant = req_valid && link_up && class_ok && (&room);
        stall = req_valid && !grant;
    end
endmodule

// File: rtl/pcie_tx_credit_gate_chk.sv
// Property checker for the transmit credit gate, bound to every instance.
module pcie_tx_credit_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       link_up,
    input logic       req_valid,
    input logic [1:0] lim_sel,
    input logic       grant,
    input logic       stall
);
    // R2
    no_grant_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> !grant);

    // R3
    sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_sel != 2'd3);

    // R3
    sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_sel == 2'd2) |=> (lim_sel == 2'd0));

    // R3
    sel_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_sel == 2'd0) |=> (lim_sel == 2'd1));

    // R6
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (req_valid && !stall));
endmodule

bind pcie_tx_credit_gate pcie_tx_credit_gate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .req_valid(req_valid),
    .lim_sel(lim_sel), .grant(grant), .stall(stall)
);

// File: tb/sim_pcie_tx_credit_gate.sv
module sim_pcie_tx_credit_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic [5:0]  core_use = '0;
    logic [5:0]  unlimited = '0;
    logic [1:0]  lim_sel;
    logic [7:0]  lim_hdr;
    logic [11:0] lim_dat;
    logic        req_valid = 1'b0;
    logic [1:0]  req_class = '0;
    logic        req_data = 1'b0;
    logic [9:0]  req_dw = '0;
    logic        grant, stall;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  bh [3];
    logic [11:0] bd [3];

    always #4 clk = ~clk;

    pcie_tx_credit_gate u0 (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .core_use(core_use),
        .unlimited(unlimited), .lim_sel(lim_sel), .lim_hdr(lim_hdr),
        .lim_dat(lim_dat), .req_valid(req_valid), .req_class(req_class),
        .req_data(req_data), .req_dw(req_dw), .grant(grant), .stall(stall)
    );

    // Core model: limits follow the selector in the same cycle.
    always_comb begin
        case (lim_sel)
            2'd0:    begin lim_hdr = bh[0]; lim_dat = bd[0]; end
            2'd1:    begin lim_hdr = bh[1]; lim_dat = bd[1]; end
            2'd2:    begin lim_hdr = bh[2]; lim_dat = bd[2]; end
            default: begin lim_hdr = '0;    lim_dat = '0;    end
        endcase
    end

    task automatic check(input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    // One request cycle with optional core pulses; checks grant and stall.
    task automatic step(input logic [1:0] cls, input logic hd, input logic [9:0] dw,
                        input logic [5:0] core, input logic exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_class = cls; req_data = hd; req_dw = dw; core_use = core;
        #2;
        check(grant, exp, {tag, " grant"});
        check(stall, !exp, {tag, " stall (R6)"});
        @(posedge clk); #1;
        req_valid = 1'b0; core_use = '0;
    endtask

    task automatic pulse(input logic [5:0] core);
        @(negedge clk); core_use = core;
        @(posedge clk); #1; core_use = '0;
    endtask

    // {class, has_data, dwords, expected grant}
    localparam logic [13:0] VEC [12] = '{
        {2'd0, 1'b1, 10'd16, 1'b1},
        {2'd0, 1'b1, 10'd25, 1'b0},
        {2'd0, 1'b1, 10'd24, 1'b1},
        {2'd0, 1'b0, 10'd0,  1'b1},
        {2'd0, 1'b1, 10'd1,  1'b0},
        {2'd1, 1'b0, 10'd0,  1'b1},
        {2'd1, 1'b1, 10'd4,  1'b1},
        {2'd1, 1'b0, 10'd0,  1'b0},
        {2'd2, 1'b1, 10'd32, 1'b1},
        {2'd2, 1'b0, 10'd0,  1'b1},
        {2'd0, 1'b0, 10'd0,  1'b1},
        {2'd0, 1'b0, 10'd0,  1'b0}
    };

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bh[0] = 8'd4; bd[0] = 12'd10;
        bh[1] = 8'd2; bd[1] = 12'd2;
        bh[2] = 8'd3; bd[2] = 12'd8;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(grant, 1'b0, "R1 reset grant");
        check(stall, 1'b0, "R1 reset stall");
        check(lim_sel == 2'd0, 1'b1, "R1 reset select");
        rst_n = 1'b1;
        @(negedge clk);
        check(lim_sel == 2'd1, 1'b1, "R3 select step");
        link_up = 1'b1;
        repeat (4) @(posedge clk);

        // R4 R5 R7: table of requests against fixed limits
        foreach (VEC[i]) begin
            step(VEC[i][13:12], VEC[i][11], VEC[i][10:1], 6'b0, VEC[i][0],
                 $sformatf("R4/R5/R7 vec %0d", i));
        end

        // R8: core completion header pulse uses last completion header credit
        pulse(6'b000010);
        step(2'd2, 1'b0, 10'd0, 6'b0, 1'b0, "R8 core pulse counted");

        // R10: unlimited completion header bypasses the check
        unlimited = 6'b000010;
        step(2'd2, 1'b0, 10'd0, 6'b0, 1'b1, "R10 unlimited");
        unlimited = '0;

        // R9: same-cycle grant and core pulse on posted header
        bh[0] = 8'd6;
        repeat (4) @(posedge clk);
        step(2'd0, 1'b0, 10'd0, 6'b100000, 1'b1, "R9 joint cycle");
        step(2'd0, 1'b0, 10'd0, 6'b0, 1'b0, "R9 both added");

        // R5: limit below count wraps to plenty of room
        bh[0] = 8'd2;
        repeat (4) @(posedge clk);
        step(2'd0, 1'b0, 10'd0, 6'b0, 1'b1, "R5 modulo room");

        // R2: link down blocks grants and ignores core pulses
        @(negedge clk); link_up = 1'b0;
        step(2'd1, 1'b0, 10'd0, 6'b0, 1'b0, "R2 link down");
        pulse(6'b001000);
        @(negedge clk); link_up = 1'b1;
        #2;
        req_valid = 1'b1; req_class = 2'd1; req_data = 1'b0;
        #1;
        check(grant, 1'b0, "R3 limits not yet stored");
        @(posedge clk); #1; req_valid = 1'b0;
        repeat (4) @(posedge clk);

        // R11: non-posted header count cleared (limit 2)
        step(2'd1, 1'b0, 10'd0, 6'b0, 1'b1, "R11 cleared 1");
        step(2'd1, 1'b0, 10'd0, 6'b0, 1'b1, "R11/R2 cleared 2");
        step(2'd1, 1'b0, 10'd0, 6'b0, 1'b0, "R11 limit reached");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule